// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block keeps the tap setting of an output delay line and delays a one-bit signal by that many stages. The setting is a 5-bit count from 0 to 31. A synchronous control port on `ctl_clk` can step it up or down by one, reload it, clear it or stage a new value ahead of a transfer. The delay line is a chain of registers on `fast_clk`, and the tap setting selects the stage that drives `dout`.

An elaboration parameter selects one of four update modes:
- **Fixed**: the tap never changes.
- **Step**: the tap is stepped up or down, and a reload returns it to the start value.
- **Direct load**: a reload takes the tap from the load input.
- **Staged load**: values are first held in a staging register, and a later reload moves the staged value into the tap.

A polarity-flip flag starts a short lockout. During the lockout all control requests are dropped, which covers the time a clock inversion needs to settle.

Top module: `tap_delay_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low) the tap equals `INIT_TAP` in fixed and step modes. It equals 0 in both load modes, where `INIT_TAP` is ignored.
- R2: In fixed mode (`MODE` = `TM_FIXED`) the tap stays at `INIT_TAP` whatever the control inputs do.
- R3: In the three variable modes the tap changes only on a rising `ctl_clk` edge. With `step_en` high, `step_up` high adds one and `step_up` low subtracts one. With `step_en` low and no reload or clear, the tap holds.
- R4: Stepping up from 31 gives 0, and stepping down from 0 gives 31.
- R5: In step mode, `load_strobe` restores the tap to `INIT_TAP`.
- R6: In direct-load mode, `load_strobe` copies `load_val` into the tap.
- R7: In staged-load mode, `stage_en` copies `load_val` into a staging register without touching the tap, and `load_strobe` copies the staging register into the tap. If both occur on one edge, the tap takes the value staged before that edge. In direct-load mode, `stage_en` alone has no effect.
- R8: `load_strobe` wins over `step_en` on the same edge.
- R9: `tap_clear` sets the tap to 0. If `stage_en` is high on the same edge, the tap takes `load_val` instead. `tap_clear` wins over `load_strobe`.
- R10: `tap_out` shows the tap in the two load modes and reads 0 in fixed and step modes.
- R11: All controls are ignored on an edge where `pol_flip` is sampled high and on the two edges after it.
- R12: `dout` equals `din` delayed by tap + 1 `fast_clk` cycles, so a tap of 0 gives one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock; all control inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pol_flip | input | 1 | Flag that the control clock polarity was switched; starts the lockout |
| step_en | input | 1 | Enables a one-step move of the tap |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| load_strobe | input | 1 | Reload request (start value, load input or staged value by mode) |
| stage_en | input | 1 | Staging-register capture; also selects the load value on a clear |
| tap_clear | input | 1 | Synchronous tap clear |
| load_val | input | 5 | Value for loads, staging and clear-with-load |
| tap_out | output | 5 | Current tap in load modes, zero otherwise |
| fast_clk | input | 1 | Sample clock of the register delay chain |
| din | input | 1 | Signal to be delayed |
| dout | output | 1 | Delayed signal |

## Verification
Two requests that can land on the same control edge are a reload and a step, and in staged mode a reload and a staging capture. The bench drives both kinds of pair on a single edge. It then judges the result from `tap_out`. In a reload-plus-step edge the loaded value must appear, not loaded plus one. In a reload-plus-capture edge the value staged earlier must appear, not the new `load_val`. In step mode the tap is not visible on `tap_out`, so the same collisions are judged from the measured `dout` latency.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;
   typedef enum logic [1:0] {
      TM_FIXED  = 2'd0,
      TM_STEP   = 2'd1,
      TM_LOAD   = 2'd2,
      TM_STAGED = 2'd3
   } tap_mode_e;
endpackage

// File: rtl/tap_lockout.sv
module tap_lockout #(
   parameter int LOCK_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pol_flip,
   output logic ctl_ok
);
   localparam int CNT_W = $clog2(LOCK_CYC + 1);

   logic [CNT_W-1:0] lock_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_cnt <= '0;
      end else if (pol_flip) begin
         lock_cnt <= CNT_W'(LOCK_CYC);
      end else if (lock_cnt != '0) begin
         lock_cnt <= lock_cnt - CNT_W'(1);
      end
   end

   assign ctl_ok = !pol_flip && (lock_cnt == '0);
endmodule

// File: rtl/tap_state.sv
module tap_state
   import tap_delay_pkg::*;
#(
   parameter tap_mode_e MODE     = TM_FIXED,
   parameter int        TAP_W    = 5,
   parameter int        INIT_TAP = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_ok,
   input  logic             step_en,
   input  logic             step_up,
   input  logic             load_strobe,
   input  logic             stage_en,
   input  logic             tap_clear,
   input  logic [TAP_W-1:0] load_val,
   output logic [TAP_W-1:0] tap_q
);
   localparam logic [TAP_W-1:0] INIT_VAL = TAP_W'(INIT_TAP);
   localparam logic [TAP_W-1:0] ONE      = TAP_W'(1);
   localparam logic [TAP_W-1:0] RST_VAL  = (MODE == TM_STEP) ? INIT_VAL : '0;

   generate
      if (MODE == TM_FIXED) begin : g_fixed
         logic unused_ctl;
         assign unused_ctl = ^{clk, rst_n, ctl_ok, step_en, step_up,
                               load_strobe, stage_en, tap_clear, load_val};
         assign tap_q = INIT_VAL;
      end else begin : g_var
         logic [TAP_W-1:0] tap_r;
         logic [TAP_W-1:0] reload_val;
         logic [TAP_W-1:0] next_tap;

         if (MODE == TM_STAGED) begin : g_staged
            logic [TAP_W-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q <= '0;
               end else if (ctl_ok && stage_en) begin
                  stage_q <= load_val;
               end
            end
            assign reload_val = stage_q;
         end else if (MODE == TM_LOAD) begin : g_direct
            assign reload_val = load_val;
         end else begin : g_step
            assign reload_val = INIT_VAL;
         end

         always_comb begin
            next_tap = tap_r;
            if (ctl_ok) begin
               if (tap_clear) begin
                  next_tap = stage_en ? load_val : '0;
               end else if (load_strobe) begin
                  next_tap = reload_val;
               end else if (step_en) begin
                  next_tap = step_up ? tap_r + ONE : tap_r - ONE;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tap_r <= RST_VAL;
            end else begin
               tap_r <= next_tap;
            end
         end

         assign tap_q = tap_r;
      end
   endgenerate
endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
   parameter int TAP_W = 5
) (
   input  logic             fast_clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [TAP_W-1:0] tap_sel,
   output logic             dout
);
   localparam int DEPTH = 1 << TAP_W;

   logic [DEPTH-1:0] chain;

   always_ff @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[DEPTH-2:0], din};
      end
   end

   assign dout = chain[tap_sel];
endmodule

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl
   import tap_delay_pkg::*;
#(
   parameter tap_mode_e MODE     = TM_FIXED,
   parameter int        TAP_W    = 5,
   parameter int        INIT_TAP = 0,
   parameter int        LOCK_CYC = 2
) (
   input  logic             ctl_clk,
   input  logic             rst_n,
   input  logic             pol_flip,
   input  logic             step_en,
   input  logic             step_up,
   input  logic             load_strobe,
   input  logic             stage_en,
   input  logic             tap_clear,
   input  logic [TAP_W-1:0] load_val,
   output logic [TAP_W-1:0] tap_out,
   input  logic             fast_clk,
   input  logic             din,
   output logic             dout
);
   localparam int  TAP_MAX    = (1 << TAP_W) - 1;
   localparam bit  SHOW_TAP   = (MODE == TM_LOAD) || (MODE == TM_STAGED);

   generate
      if (TAP_W < 2 || TAP_W > 8) begin : g_bad_width
         $error("tap_delay_ctrl: TAP_W must lie in 2..8");
      end
      if (INIT_TAP < 0 || INIT_TAP > TAP_MAX) begin : g_bad_init
         $error("tap_delay_ctrl: INIT_TAP outside tap range");
      end
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("tap_delay_ctrl: LOCK_CYC must be at least 1");
      end
   endgenerate

   logic             ctl_ok;
   logic [TAP_W-1:0] tap_q;

   tap_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk      (ctl_clk),
      .rst_n    (rst_n),
      .pol_flip (pol_flip),
      .ctl_ok   (ctl_ok)
   );

   tap_state #(.MODE(MODE), .TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_state (
      .clk         (ctl_clk),
      .rst_n       (rst_n),
      .ctl_ok      (ctl_ok),
      .step_en     (step_en),
      .step_up     (step_up),
      .load_strobe (load_strobe),
      .stage_en    (stage_en),
      .tap_clear   (tap_clear),
      .load_val    (load_val),
      .tap_q       (tap_q)
   );

   tap_delay_line #(.TAP_W(TAP_W)) u_line (
      .fast_clk (fast_clk),
      .rst_n    (rst_n),
      .din      (din),
      .tap_sel  (tap_q),
      .dout     (dout)
   );

   generate
      if (SHOW_TAP) begin : g_show
         assign tap_out = tap_q;
      end else begin : g_hide
         assign tap_out = '0;
      end
   endgenerate
endmodule

// File: rtl/tap_delay_ctrl_chk.sv
module tap_delay_ctrl_chk
   import tap_delay_pkg::*;
#(
   parameter tap_mode_e MODE  = TM_FIXED,
   parameter int        TAP_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pol_flip,
   input logic             step_en,
   input logic             step_up,
   input logic             load_strobe,
   input logic             stage_en,
   input logic             tap_clear,
   input logic [TAP_W-1:0] load_val,
   input logic             ctl_ok,
   input logic [TAP_W-1:0] tap_q
);
   localparam logic [TAP_W-1:0] ONE = TAP_W'(1);

   generate
      if (MODE == TM_FIXED) begin : g_fixed
         logic unused_chk;
         assign unused_chk = ^{clk, rst_n, pol_flip, step_en, step_up, load_strobe,
                               stage_en, tap_clear, load_val, ctl_ok, tap_q};
      end else begin : g_var
         a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_ok && step_en && step_up && !load_strobe && !tap_clear)
            |=> tap_q == $past(tap_q) + ONE);

         a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_ok && step_en && !step_up && !load_strobe && !tap_clear)
            |=> tap_q == $past(tap_q) - ONE);

         a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!step_en && !load_strobe && !tap_clear) |=> $stable(tap_q));

         a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_ok && tap_clear && !stage_en) |=> tap_q == '0);

         a_r9_clear_load: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_ok && tap_clear && stage_en) |=> tap_q == $past(load_val));

         a_r11_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            pol_flip |-> !ctl_ok);

         a_r11_hold_now: assert property (@(posedge clk) disable iff (!rst_n)
            pol_flip |=> $stable(tap_q));

         a_r11_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pol_flip) |=> $stable(tap_q));

         if (MODE == TM_LOAD) begin : g_load
            a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
               (ctl_ok && load_strobe && !tap_clear) |=> tap_q == $past(load_val));
         end
      end
   endgenerate
endmodule

bind tap_delay_ctrl tap_delay_ctrl_chk #(.MODE(MODE), .TAP_W(TAP_W)) u_chk (
   .clk         (ctl_clk),
   .rst_n       (rst_n),
   .pol_flip    (pol_flip),
   .step_en     (step_en),
   .step_up     (step_up),
   .load_strobe (load_strobe),
   .stage_en    (stage_en),
   .tap_clear   (tap_clear),
   .load_val    (load_val),
   .ctl_ok      (ctl_ok),
   .tap_q       (tap_q)
);

// File: tb/test_tap_delay_ctrl.sv
module test_tap_delay_ctrl;
   import tap_delay_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int INIT = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pol_flip = 1'b0;
   logic       step_en = 1'b0;
   logic       step_up = 1'b0;
   logic       load_strobe = 1'b0;
   logic       stage_en = 1'b0;
   logic       tap_clear = 1'b0;
   logic [4:0] load_val = '0;
   logic       din = 1'b0;

   logic [4:0] out_fix, out_step, out_load, out_stg;
   logic       dout_fix, dout_step, dout_load, dout_stg;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tap_delay_ctrl #(.MODE(TM_FIXED), .INIT_TAP(INIT)) i_tap_delay_ctrl_fix (
      .ctl_clk(clk), .rst_n(rst_n), .pol_flip(pol_flip), .step_en(step_en),
      .step_up(step_up), .load_strobe(load_strobe), .stage_en(stage_en),
      .tap_clear(tap_clear), .load_val(load_val), .tap_out(out_fix),
      .fast_clk(clk), .din(din), .dout(dout_fix));

   tap_delay_ctrl #(.MODE(TM_STEP), .INIT_TAP(INIT)) i_tap_delay_ctrl_step (
      .ctl_clk(clk), .rst_n(rst_n), .pol_flip(pol_flip), .step_en(step_en),
      .step_up(step_up), .load_strobe(load_strobe), .stage_en(stage_en),
      .tap_clear(tap_clear), .load_val(load_val), .tap_out(out_step),
      .fast_clk(clk), .din(din), .dout(dout_step));

   tap_delay_ctrl #(.MODE(TM_LOAD), .INIT_TAP(INIT)) i_tap_delay_ctrl_load (
      .ctl_clk(clk), .rst_n(rst_n), .pol_flip(pol_flip), .step_en(step_en),
      .step_up(step_up), .load_strobe(load_strobe), .stage_en(stage_en),
      .tap_clear(tap_clear), .load_val(load_val), .tap_out(out_load),
      .fast_clk(clk), .din(din), .dout(dout_load));

   tap_delay_ctrl #(.MODE(TM_STAGED), .INIT_TAP(INIT)) i_tap_delay_ctrl (
      .ctl_clk(clk), .rst_n(rst_n), .pol_flip(pol_flip), .step_en(step_en),
      .step_up(step_up), .load_strobe(load_strobe), .stage_en(stage_en),
      .tap_clear(tap_clear), .load_val(load_val), .tap_out(out_stg),
      .fast_clk(clk), .din(din), .dout(dout_stg));

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one control edge; caller stands at a falling edge
   task automatic drive(input logic se, input logic su, input logic ld,
                        input logic sg, input logic clr, input logic flip,
                        input logic [4:0] v);
      step_en = se; step_up = su; load_strobe = ld; stage_en = sg;
      tap_clear = clr; pol_flip = flip; load_val = v;
      @(negedge clk);
      step_en = 0; step_up = 0; load_strobe = 0; stage_en = 0;
      tap_clear = 0; pol_flip = 0; load_val = '0;
   endtask

   task automatic up();   drive(1, 1, 0, 0, 0, 0, 5'd0); endtask
   task automatic down(); drive(1, 0, 0, 0, 0, 0, 5'd0); endtask
   task automatic clear(); drive(0, 0, 0, 0, 1, 0, 5'd0); endtask
   task automatic load(input logic [4:0] v); drive(0, 0, 1, 0, 0, 0, v); endtask

   // latency in fast cycles minus one, i.e. the effective tap
   task automatic measure(output int l_fix, output int l_step,
                          output int l_load, output int l_stg);
      l_fix = -1; l_step = -1; l_load = -1; l_stg = -1;
      din = 1'b0;
      repeat (36) @(negedge clk);
      din = 1'b1;
      @(negedge clk);
      din = 1'b0;
      for (int c = 0; c < 40; c++) begin
         if (dout_fix  && l_fix  < 0) l_fix  = c;
         if (dout_step && l_step < 0) l_step = c;
         if (dout_load && l_load < 0) l_load = c;
         if (dout_stg  && l_stg  < 0) l_stg  = c;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      int lf, ls, ll, lg;
      check("R1 load tap_out after reset", out_load, 0);
      check("R1 staged tap_out after reset", out_stg, 0);
      check("R10 step tap_out hidden", out_step, 0);
      check("R10 fixed tap_out hidden", out_fix, 0);
      measure(lf, ls, ll, lg);
      check("R2 fixed start tap", lf, INIT);
      check("R1 step start tap", ls, INIT);
      check("R1 load start tap", ll, 0);
      check("R12 staged tap0 latency", lg, 0);
   endtask

   task automatic t_fixed();
      int lf, ls, ll, lg;
      up();
      load(5'd3);
      drive(0, 0, 0, 1, 1, 0, 5'd20);
      down();
      measure(lf, ls, ll, lg);
      check("R2 fixed ignores controls", lf, INIT);
   endtask

   task automatic t_step();
      int lf, ls, ll, lg;
      clear();
      up(); up(); up();
      check("R3 three steps up", out_load, 3);
      check("R10 step mode tap_out zero", out_step, 0);
      down();
      check("R3 step down", out_load, 2);
      @(negedge clk);
      check("R3 hold without step_en", out_load, 2);
      measure(lf, ls, ll, lg);
      check("R3 step tap via latency", ls, 2);
      load(5'd30);
      check("R6 direct load", out_load, 30);
      measure(lf, ls, ll, lg);
      check("R5 step reload start value", ls, INIT);
   endtask

   task automatic t_wrap();
      int lf, ls, ll, lg;
      load(5'd31);
      up();
      check("R4 wrap up 31->0", out_load, 0);
      down();
      check("R4 wrap down 0->31", out_load, 31);
      clear();
      down();
      measure(lf, ls, ll, lg);
      check("R4 step wrap down", ls, 31);
   endtask

   task automatic t_stage();
      clear();
      drive(0, 0, 0, 1, 0, 0, 5'd20);
      check("R7 staging leaves tap", out_stg, 0);
      check("R7 stage_en no effect in load mode", out_load, 0);
      load(5'd5);
      check("R7 transfer staged value", out_stg, 20);
      check("R6 load takes load_val", out_load, 5);
      drive(0, 0, 0, 1, 0, 0, 5'd25);
      check("R7 restage keeps tap", out_stg, 20);
      drive(0, 0, 1, 1, 0, 0, 5'd7);
      check("R7 same-edge stage and load", out_stg, 25);
      load(5'd11);
      check("R7 later transfer", out_stg, 7);
   endtask

   task automatic t_prio();
      int lf, ls, ll, lg;
      clear();
      up(); up();
      drive(1, 1, 1, 0, 0, 0, 5'd6);
      check("R8 load beats step (load)", out_load, 6);
      check("R8 load beats step (staged)", out_stg, 7);
      measure(lf, ls, ll, lg);
      check("R8 load beats step (step)", ls, INIT);
   endtask

   task automatic t_clear();
      load(5'd13);
      clear();
      check("R9 clear to zero", out_load, 0);
      load(5'd13);
      drive(0, 0, 0, 1, 1, 0, 5'd22);
      check("R9 clear with stage_en loads", out_load, 22);
      check("R9 clear with stage_en staged", out_stg, 22);
      drive(0, 0, 1, 0, 1, 0, 5'd4);
      check("R9 clear beats load", out_load, 0);
   endtask

   task automatic t_lock();
      clear();
      drive(1, 1, 0, 0, 0, 1, 5'd0);
      check("R11 flip edge ignored", out_load, 0);
      up();
      check("R11 first lock edge", out_load, 0);
      load(5'd17);
      check("R11 second lock edge", out_load, 0);
      up();
      check("R11 control back", out_load, 1);
   endtask

   task automatic t_delay();
      int lf, ls, ll, lg;
      clear();
      repeat (5) up();
      measure(lf, ls, ll, lg);
      check("R12 step latency 5", ls, 5);
      check("R12 load latency 5", ll, 5);
      load(5'd31);
      measure(lf, ls, ll, lg);
      check("R12 load latency 31", ll, 31);
      load(5'd0);
      measure(lf, ls, ll, lg);
      check("R12 load latency 0", ll, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed();
      t_step();
      t_wrap();
      t_stage();
      t_prio();
      t_clear();
      t_lock();
      t_delay();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule